// File: doc/BRIEF.md
# Multi-Function GPIO Port Controller

This block controls eight general-purpose pads that are shared with touch-electrode inputs. Each pad can be switched off (high impedance). It can also be a plain input, an input with a pull-down or pull-up, a push-pull output, or an open-drain output that drives only the high side or only the low side. Software sets the mode through five register bytes: two control bytes, a direction byte, an enable byte and a data byte. Three write-one strobe offsets set, clear or toggle chosen data bits without a read-modify-write.

Bit b of every register byte belongs to port b+4. Pads that the electrode-count input claims for sensing are forced off while the system is in run mode. A new output level reaches the pads only at the end of the current conversion. Input levels are captured once per measurement cycle. For input ports, a read of the data offset returns that captured level.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While reset is asserted and after reset, all register bytes read 0, and pad_oe_o, pad_pu_o, pad_pd_o and pad_do_o are all 0.
- R2: A write with wr_en_i=1 takes effect at the next clock edge. Offset 0x73 is control byte A, 0x74 is control byte B, 0x76 is direction and 0x77 is enable. Each of these reads back as written. Any offset outside 0x73..0x7A reads 0, and writes to it change nothing.
- R3: A port that is enabled, not overridden and has direction 0 is an input and has pad_oe_o=0. Its pulls are set by {A,B}: 10 gives pad_pd_o=1, 11 gives pad_pu_o=1, and 00 or 01 gives no pull. A port in any other mode has both pulls at 0.
- R4: A port that is enabled, not overridden and has direction 1 is an output. {A,B} 00 or 01 gives pad_oe_o=1. 11 (high-side open drain) gives pad_oe_o equal to the applied level. 10 (low-side open drain) gives pad_oe_o equal to the inverse of the applied level. A disabled port has pad_oe_o=0.
- R5: A write to 0x78 sets, to 0x79 clears and to 0x7A toggles the data bits that are 1 in the write data. Bits written as 0 keep their value.
- R6: A read of 0x78, 0x79 or 0x7A returns the data byte as stored.
- R7: pin_i is captured when sample_i=1. A read of 0x75 returns, for each bit, the captured pin level if that port is an effective input (R3), and the stored data bit otherwise. A write to 0x75 replaces the data byte and does not change the captured levels.
- R8: When run_mode_i=1 and ele_cnt_i > b+4, port b behaves as disabled, whatever its enable bit holds. The override disappears in the same cycle that its condition goes away.
- R9: pad_do_o carries the applied level. The applied level takes the stored data byte at a clock edge where conv_done_i=1 and holds its value at every other edge.
- R10: All register writes are accepted whether run_mode_i is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register offset for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| run_mode_i | input | 1 | 1 = run mode; electrode override active |
| ele_cnt_i | input | 4 | Number of ports claimed as electrodes |
| conv_done_i | input | 1 | End-of-conversion strobe; applies pending output level |
| sample_i | input | 1 | Input capture strobe |
| pin_i | input | 8 | Pad input levels, bit b = port b+4 |
| pad_oe_o | output | 8 | Pad drive enable per port |
| pad_do_o | output | 8 | Applied output level per port |
| pad_pu_o | output | 8 | Pull-up enable per port |
| pad_pd_o | output | 8 | Pull-down enable per port |

## Verification
A register write or strobe changes stored state at the next rising edge, and rdata_o shows it as soon as that edge has passed. The mode decode and the override act combinationally on run_mode_i and ele_cnt_i within the same cycle. The applied level and the captured inputs change only at an edge where their strobe was high. The bench drives all inputs just after a falling edge and compares every output against its reference model 1 ns later, before the next rising edge. The model then advances at that rising edge using the inputs that were present before it, so each result is checked in the first cycle in which it is due.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam logic [7:0] OFS_CTLA = 8'h73;
  localparam logic [7:0] OFS_CTLB = 8'h74;
  localparam logic [7:0] OFS_DATA = 8'h75;
  localparam logic [7:0] OFS_DIR  = 8'h76;
  localparam logic [7:0] OFS_EN   = 8'h77;
  localparam logic [7:0] OFS_SET  = 8'h78;
  localparam logic [7:0] OFS_CLR  = 8'h79;
  localparam logic [7:0] OFS_TOG  = 8'h7A;

  typedef enum logic [2:0] {
    PM_OFF, PM_IN, PM_IN_PD, PM_IN_PU, PM_PP, PM_OD_HI, PM_OD_LO
  } port_mode_e;

  function automatic port_mode_e decode_mode(logic en, logic dir, logic a, logic b);
    if (!en)      return PM_OFF;
    if (!dir) begin
      case ({a, b})
        2'b10:   return PM_IN_PD;
        2'b11:   return PM_IN_PU;
        default: return PM_IN;
      endcase
    end
    case ({a, b})
      2'b11:   return PM_OD_HI;
      2'b10:   return PM_OD_LO;
      default: return PM_PP;
    endcase
  endfunction
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int NP = 8,
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [NP-1:0] wdata_i,
  output logic [NP-1:0] ctla_o,
  output logic [NP-1:0] ctlb_o,
  output logic [NP-1:0] dir_o,
  output logic [NP-1:0] en_o,
  output logic [NP-1:0] data_o
);
  logic [NP-1:0] ctla_q, ctlb_q, dir_q, en_q, data_q;
  logic [7:0]    ofs;

  assign ofs = 8'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctla_q <= '0;
      ctlb_q <= '0;
      dir_q  <= '0;
      en_q   <= '0;
      data_q <= '0;
    end else if (wr_en_i) begin
      case (ofs)
        OFS_CTLA: ctla_q <= wdata_i;
        OFS_CTLB: ctlb_q <= wdata_i;
        OFS_DATA: data_q <= wdata_i;
        OFS_DIR:  dir_q  <= wdata_i;
        OFS_EN:   en_q   <= wdata_i;
        OFS_SET:  data_q <= data_q | wdata_i;
        OFS_CLR:  data_q <= data_q & ~wdata_i;
        OFS_TOG:  data_q <= data_q ^ wdata_i;
        default:  ;
      endcase
    end
  end

  assign ctla_o = ctla_q;
  assign ctlb_o = ctlb_q;
  assign dir_o  = dir_q;
  assign en_o   = en_q;
  assign data_o = data_q;

  // R5
  set_hits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ofs == OFS_SET) |=> ((data_q & $past(wdata_i)) == $past(wdata_i)));
  // R5
  clr_hits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ofs == OFS_CLR) |=> ((data_q & $past(wdata_i)) == '0));
  // R5
  tog_keeps_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ofs == OFS_TOG) |=> ((data_q & ~$past(wdata_i)) == ($past(data_q) & ~$past(wdata_i))));
  // R2
  stray_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (ofs < OFS_CTLA || ofs > OFS_TOG)) |=>
      ($stable(ctla_q) && $stable(ctlb_q) && $stable(dir_q) && $stable(en_q) && $stable(data_q)));
endmodule

// File: rtl/gpio_io_stage.sv
module gpio_io_stage #(
  parameter int NP = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          conv_done_i,
  input  logic          sample_i,
  input  logic [NP-1:0] data_i,
  input  logic [NP-1:0] pin_i,
  output logic [NP-1:0] level_o,
  output logic [NP-1:0] pin_lat_o
);
  logic [NP-1:0] level_q, pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      pin_q   <= '0;
    end else begin
      if (conv_done_i) level_q <= data_i;  // level held through charging
      if (sample_i)    pin_q   <= pin_i;
    end
  end

  assign level_o   = level_q;
  assign pin_lat_o = pin_q;

  // R9
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_done_i |=> $stable(level_o));
  // R7
  pin_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(pin_lat_o));
endmodule

// File: rtl/gpio_port_dec.sv
module gpio_port_dec
  import gpio_port_pkg::*;
#(
  parameter int NP    = 8,
  parameter int FIRST = 4,
  parameter int CW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NP-1:0] en_i,
  input  logic [NP-1:0] dir_i,
  input  logic [NP-1:0] ctla_i,
  input  logic [NP-1:0] ctlb_i,
  input  logic [NP-1:0] level_i,
  input  logic          run_i,
  input  logic [CW-1:0] ele_cnt_i,
  output logic [NP-1:0] oe_o,
  output logic [NP-1:0] pu_o,
  output logic [NP-1:0] pd_o,
  output logic [NP-1:0] is_in_o
);
  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam int IDX = FIRST + p;
    logic       taken, eff_en;
    port_mode_e mode;

    assign taken  = run_i && (int'(ele_cnt_i) > IDX);
    assign eff_en = en_i[p] && !taken;
    assign mode   = decode_mode(eff_en, dir_i[p], ctla_i[p], ctlb_i[p]);

    always_comb begin
      oe_o[p]    = 1'b0;
      pu_o[p]    = 1'b0;
      pd_o[p]    = 1'b0;
      is_in_o[p] = 1'b0;
      case (mode)
        PM_IN:    is_in_o[p] = 1'b1;
        PM_IN_PD: begin is_in_o[p] = 1'b1; pd_o[p] = 1'b1; end
        PM_IN_PU: begin is_in_o[p] = 1'b1; pu_o[p] = 1'b1; end
        PM_PP:    oe_o[p] = 1'b1;
        PM_OD_HI: oe_o[p] = level_i[p];
        PM_OD_LO: oe_o[p] = !level_i[p];
        default:  ;
      endcase
    end

    // R8
    electrode_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      taken |-> (!oe_o[p] && !pu_o[p] && !pd_o[p]));
    // R3
    pull_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(pu_o[p] && pd_o[p]));
    // R4
    off_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[p] |-> (!oe_o[p] && !pu_o[p] && !pd_o[p]));
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NP    = 8,
  parameter int FIRST = 4,
  parameter int AW    = 8,
  parameter int CW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [NP-1:0] wdata_i,
  output logic [NP-1:0] rdata_o,
  input  logic          run_mode_i,
  input  logic [CW-1:0] ele_cnt_i,
  input  logic          conv_done_i,
  input  logic          sample_i,
  input  logic [NP-1:0] pin_i,
  output logic [NP-1:0] pad_oe_o,
  output logic [NP-1:0] pad_do_o,
  output logic [NP-1:0] pad_pu_o,
  output logic [NP-1:0] pad_pd_o
);
  logic [NP-1:0] ctla, ctlb, dir, en, data, level, pin_lat, is_in;
  logic [7:0]    ofs;

  assign ofs = 8'(addr_i);

  gpio_regs #(.NP(NP), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .ctla_o(ctla), .ctlb_o(ctlb), .dir_o(dir), .en_o(en), .data_o(data)
  );

  gpio_io_stage #(.NP(NP)) u_io (
    .clk_i, .rst_ni, .conv_done_i, .sample_i,
    .data_i(data), .pin_i, .level_o(level), .pin_lat_o(pin_lat)
  );

  gpio_port_dec #(.NP(NP), .FIRST(FIRST), .CW(CW)) u_dec (
    .clk_i, .rst_ni, .en_i(en), .dir_i(dir), .ctla_i(ctla), .ctlb_i(ctlb),
    .level_i(level), .run_i(run_mode_i), .ele_cnt_i,
    .oe_o(pad_oe_o), .pu_o(pad_pu_o), .pd_o(pad_pd_o), .is_in_o(is_in)
  );

  always_comb begin
    case (ofs)
      OFS_CTLA: rdata_o = ctla;
      OFS_CTLB: rdata_o = ctlb;
      OFS_DATA: rdata_o = (pin_lat & is_in) | (data & ~is_in);
      OFS_DIR:  rdata_o = dir;
      OFS_EN:   rdata_o = en;
      OFS_SET, OFS_CLR, OFS_TOG: rdata_o = data;
      default:  rdata_o = '0;
    endcase
  end

  assign pad_do_o = level;

  // R10
  run_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ofs == OFS_EN) |=> (en == $past(wdata_i)));
  // R6
  alias_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ofs == OFS_TOG) |-> (rdata_o == data));
endmodule

// File: tb/gpio_port_ctrl_test.sv
`timescale 1ns/1ps
module gpio_port_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] addr = '0, wdata = '0, pins = '0;
  logic       run = 1'b0, cdone = 1'b0, smp = 1'b0;
  logic [3:0] ecnt = '0;
  logic [7:0] rdata, oe, dout, pu, pd;

  int checks = 0, fails = 0;
  bit finished = 0;
  string phase = "R1";

  // reference state
  logic [7:0] m_a = '0, m_b = '0, m_dir = '0, m_en = '0, m_data = '0, m_lvl = '0, m_pin = '0;

  always #2.5 clk = ~clk;

  gpio_port_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .run_mode_i(run), .ele_cnt_i(ecnt), .conv_done_i(cdone),
    .sample_i(smp), .pin_i(pins), .pad_oe_o(oe), .pad_do_o(dout),
    .pad_pu_o(pu), .pad_pd_o(pd)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (phase %s) t=%0t actual=%02h expected=%02h", tag, phase, $time, act, exp);
    end
  endtask

  function automatic bit eff_in(int b);
    bit eff;
    eff = m_en[b] && !(run && int'(ecnt) > b + 4);
    return eff && !m_dir[b];
  endfunction

  task automatic compare_all();
    logic [7:0] e_oe, e_pu, e_pd, e_rd;
    string rtag;
    for (int b = 0; b < 8; b++) begin
      bit eff;
      eff = m_en[b] && !(run && int'(ecnt) > b + 4);
      e_oe[b] = 0; e_pu[b] = 0; e_pd[b] = 0;
      if (eff && !m_dir[b]) begin
        e_pd[b] = m_a[b] && !m_b[b];
        e_pu[b] = m_a[b] && m_b[b];
      end else if (eff) begin
        if (m_a[b] && m_b[b])       e_oe[b] = m_lvl[b];
        else if (m_a[b] && !m_b[b]) e_oe[b] = !m_lvl[b];
        else                        e_oe[b] = 1;
      end
    end
    rtag = "R2";
    case (addr)
      8'h73: e_rd = m_a;
      8'h74: e_rd = m_b;
      8'h75: begin
        rtag = "R7";
        for (int b = 0; b < 8; b++) e_rd[b] = eff_in(b) ? m_pin[b] : m_data[b];
      end
      8'h76: e_rd = m_dir;
      8'h77: e_rd = m_en;
      8'h78, 8'h79, 8'h7A: begin rtag = "R6"; e_rd = m_data; end
      default: e_rd = 8'h00;
    endcase
    check(rtag, rdata, e_rd);
    check("R4", oe, e_oe);
    check("R3", pu, e_pu);
    check("R3", pd, e_pd);
    check("R9", dout, m_lvl);
  endtask

  task automatic step(bit w, logic [7:0] a, logic [7:0] d, bit r, logic [3:0] n,
                      bit c, bit s, logic [7:0] p);
    logic [7:0] old_data;
    we = w; addr = a; wdata = d; run = r; ecnt = n; cdone = c; smp = s; pins = p;
    #1 compare_all();
    @(posedge clk);
    old_data = m_data;
    if (c) m_lvl = old_data;
    if (s) m_pin = p;
    if (w) begin
      case (a)
        8'h73: m_a = d;
        8'h74: m_b = d;
        8'h75: m_data = d;
        8'h76: m_dir = d;
        8'h77: m_en = d;
        8'h78: for (int b = 0; b < 8; b++) if (d[b]) m_data[b] = 1'b1;
        8'h79: for (int b = 0; b < 8; b++) if (d[b]) m_data[b] = 1'b0;
        8'h7A: for (int b = 0; b < 8; b++) if (d[b]) m_data[b] = !m_data[b];
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    step(1, a, d, run, ecnt, 0, 0, pins);
  endtask

  task automatic idle(logic [7:0] a);
    step(0, a, 8'h00, run, ecnt, 0, 0, pins);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: during reset
    #3;
    check("R1", rdata, 8'h00); check("R1", oe, 8'h00);
    check("R1", pu, 8'h00);    check("R1", pd, 8'h00); check("R1", dout, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 8'h73; a <= 8'h7A; a++) idle(8'(a));  // R1 after reset

    phase = "R2";
    wr(8'h73, 8'hA5); wr(8'h74, 8'h3C); wr(8'h76, 8'h0F); wr(8'h77, 8'hF0);
    for (int a = 8'h72; a <= 8'h7B; a++) idle(8'(a));
    wr(8'h10, 8'hFF); wr(8'h7B, 8'hFF); wr(8'h72, 8'hFF);
    idle(8'h10); idle(8'h73); idle(8'h77);

    phase = "R3";  // all inputs, cover each {A,B}
    wr(8'h77, 8'hFF); wr(8'h76, 8'h00);
    wr(8'h73, 8'b1100_1100); wr(8'h74, 8'b1010_1010); idle(8'h75);

    phase = "R7";
    step(0, 8'h75, 8'h00, 0, 0, 0, 1, 8'h5A); idle(8'h75);
    wr(8'h75, 8'hFF); idle(8'h75);
    step(0, 8'h75, 8'h00, 0, 0, 0, 0, 8'hC3); idle(8'h75);  // no sample: unchanged
    wr(8'h76, 8'h0F); idle(8'h75);

    phase = "R4";
    wr(8'h76, 8'hFF);
    step(0, 8'h75, 8'h00, 0, 0, 1, 0, pins); idle(8'h75);
    wr(8'h75, 8'h00); idle(8'h75);
    phase = "R9";
    step(0, 8'h75, 8'h00, 0, 0, 0, 0, pins);
    step(1, 8'h75, 8'h55, 0, 0, 1, 0, pins);  // applies old data
    step(0, 8'h75, 8'h00, 0, 0, 1, 0, pins); idle(8'h75);

    phase = "R5";
    wr(8'h78, 8'h81); idle(8'h78);
    wr(8'h79, 8'h05); idle(8'h79);
    wr(8'h7A, 8'hF0); idle(8'h7A);
    wr(8'h78, 8'h00); wr(8'h79, 8'h00); wr(8'h7A, 8'h00);
    phase = "R6";
    idle(8'h78); idle(8'h79); idle(8'h7A);

    phase = "R8";
    wr(8'h77, 8'hFF); wr(8'h73, 8'h0F); wr(8'h74, 8'h33);
    for (int n = 0; n < 16; n++) begin
      step(0, 8'h75, 8'h00, 1, 4'(n), 0, 0, pins);
      step(0, 8'h75, 8'h00, 0, 4'(n), 0, 0, pins);
    end
    wr(8'h76, 8'h00);
    for (int n = 0; n < 16; n++) step(0, 8'h75, 8'h00, 1, 4'(n), 0, 0, pins);

    phase = "R10";
    step(1, 8'h77, 8'h3C, 1, 4'd15, 0, 0, pins); idle(8'h77);
    step(1, 8'h76, 8'hC3, 1, 4'd6, 0, 0, pins); idle(8'h76);
    step(1, 8'h7A, 8'hFF, 1, 4'd9, 1, 0, pins); idle(8'h75);

    phase = "mixed";
    for (int i = 0; i < 2000; i++) begin
      logic [7:0] ra;
      ra = (($urandom % 8) == 0) ? 8'($urandom) : 8'(8'h73 + ($urandom % 8));
      step(1'($urandom), ra, 8'($urandom), 1'($urandom), 4'($urandom),
           (($urandom % 4) == 0), (($urandom % 3) == 0), 8'($urandom));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule